// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows the stages of a control transfer on endpoint 0 of a USB device controller. Its inputs are single-cycle events: a SETUP packet has arrived (with its direction bit and its wLength field), an IN data packet has been handed off, an OUT data packet has arrived (with its byte count), the completion of the final IN packet, and a request to stall the endpoint. From these events it keeps a stage state and a remaining-byte count. It drives single-cycle strobes that arm the transmit side, arm the receive side or start the status stage, and a level output that holds the endpoint stalled.

The state is encoded as follows: SETUP = 1, TX = 2, RX = 3, TX_END = 4, STALL = 5. SETUP means the block is idle, waiting for a SETUP packet, or has just taken a SETUP packet that has no data stage.

The transitions are:
- **setup_nodata**: a SETUP with zero length, to SETUP.
- **setup_in**: a SETUP with nonzero length and direction IN, to TX.
- **setup_out**: a SETUP with nonzero length and direction OUT, to RX.
- **tx_more**: from TX back to TX.
- **tx_last**: from TX to TX_END.
- **tx_done**: from TX_END to SETUP.
- **rx_more**: from RX back to RX.
- **rx_end**: from RX to SETUP.
- **stall_enter**: from any state to STALL.
- **stall_exit**: a SETUP taken while in STALL.

A SETUP taken in any state other than STALL restarts the transfer. All outputs are registered.

Top module: `ep0_stage_seq`

## Requirements
- R1: After reset, `state` is 1 (SETUP). `arm_tx`, `arm_rx`, `send_status` and `ep_stall` are all 0.
- R2: A SETUP event with `setup_len` of 0 leaves the block in SETUP (1) and pulses `send_status` for one cycle.
- R3: A SETUP event with nonzero length does one of two things, and loads the remaining count with `setup_len`:
  - With `setup_in` = 1 it moves to TX (2) and pulses `arm_tx`.
  - With `setup_in` = 0 it moves to RX (3) and pulses `arm_rx`.
- R4: In TX, `in_sent` with a remaining count greater than MPS (default 64) stays in TX. It pulses `arm_tx` and lowers the remaining count by MPS.
- R5: In TX, `in_sent` with a remaining count of at most MPS moves to TX_END (4). No strobe is pulsed.
- R6: TX_END holds until `in_done`. Then the block moves to SETUP and pulses `send_status`. `in_done` in any other state is ignored.
- R7: In RX, `out_rcvd` with `out_len` < MPS (a short packet) moves to SETUP and pulses `send_status`.
- R8: In RX, a full packet (`out_len` = MPS) is handled by comparing it with the remaining count:
  - If it is not smaller than the remaining count, the block moves to SETUP and pulses `send_status`.
  - Otherwise the block stays in RX, pulses `arm_rx` and lowers the remaining count by `out_len`.
- R9: `stall_req` in any state moves the block to STALL (5), with `ep_stall` high from the next cycle. `stall_req` has priority over a SETUP event in the same cycle.
- R10: In STALL, `ep_stall` stays high until a SETUP event arrives without `stall_req`. That SETUP lowers `ep_stall` and is decoded as in R2 and R3.
- R11: A SETUP event taken in TX, RX or TX_END abandons the current transfer and is decoded as in R2 and R3.
- R12: At most one of `arm_tx`, `arm_rx` and `send_status` is high in any cycle. Events that do not belong to the current state change neither the state nor any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_valid | input | 1 | A SETUP packet was received this cycle |
| setup_in | input | 1 | Direction bit of that SETUP packet (1 = IN to host) |
| setup_len | input | LEN_W (16) | wLength field of that SETUP packet |
| in_sent | input | 1 | An IN data packet was handed off |
| out_rcvd | input | 1 | An OUT data packet was received |
| out_len | input | clog2(MPS+1) (7) | Byte count of that OUT packet |
| in_done | input | 1 | Completion of the final IN packet |
| stall_req | input | 1 | Request to stall the endpoint |
| state | output | 3 | Current stage (1 to 5) |
| arm_tx | output | 1 | Pulse: load the next IN packet |
| arm_rx | output | 1 | Pulse: accept the next OUT packet |
| send_status | output | 1 | Pulse: start the status stage |
| ep_stall | output | 1 | Endpoint stalled |

## Verification
Every output is registered, so a result is due exactly one clock after the rising edge that samples the event: `state`, the strobes and `ep_stall` all change at that edge. The bench drives each stimulus on a falling edge and lets one rising edge pass. It compares the outputs at the following falling edge with a cycle model kept in bench functions, and then drops the stimulus. A strobe is therefore seen high in exactly one sampled cycle, and a hold case such as TX_END waiting for completion is checked at each falling edge.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

    typedef enum logic [2:0] {
        ST_SETUP  = 3'd1,
        ST_TX     = 3'd2,
        ST_RX     = 3'd3,
        ST_TX_END = 3'd4,
        ST_STALL  = 3'd5
    } ep0_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_ARM_TX = 2'd1,
        ACT_ARM_RX = 2'd2,
        ACT_STATUS = 2'd3
    } ep0_act_e;

    typedef enum logic [1:0] {
        CNT_HOLD    = 2'd0,
        CNT_LOAD    = 2'd1,
        CNT_SUB_MPS = 2'd2,
        CNT_SUB_OUT = 2'd3
    } ep0_cnt_op_e;

endpackage

// File: rtl/ep0_remain_ctr.sv
module ep0_remain_ctr
    import ep0_seq_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int MPS   = 64,
    parameter int OUT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ep0_cnt_op_e       op,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [OUT_W-1:0]  out_len,
    output logic              last_in,
    output logic              rx_end
);
    localparam logic [LEN_W-1:0] MPS_L = LEN_W'(MPS);
    localparam logic [OUT_W-1:0] MPS_O = OUT_W'(MPS);

    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] out_ext;

    assign out_ext = {{(LEN_W-OUT_W){1'b0}}, out_len};

    // Final IN packet: what is left fits in one packet.
    assign last_in = (remain_q <= MPS_L);

    // OUT stage ends on a short packet or once the count is used up.
    assign rx_end  = (out_len < MPS_O) || (remain_q <= out_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else begin
            unique case (op)
                CNT_LOAD:    remain_q <= load_len;
                CNT_SUB_MPS: remain_q <= remain_q - MPS_L;
                CNT_SUB_OUT: remain_q <= remain_q - out_ext;
                default:     remain_q <= remain_q;
            endcase
        end
    end

endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
    import ep0_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_valid,
    input  logic              setup_in,
    input  logic [LEN_W-1:0]  setup_len,
    input  logic              in_sent,
    input  logic              out_rcvd,
    input  logic              in_done,
    input  logic              stall_req,
    input  logic              last_in,
    input  logic              rx_end,
    output ep0_state_e        state_q,
    output ep0_state_e        state_d,
    output ep0_act_e          act,
    output ep0_cnt_op_e       cnt_op
);

    always_comb begin
        state_d = state_q;
        act     = ACT_NONE;
        cnt_op  = CNT_HOLD;
        if (stall_req) begin
            // stall_enter: highest priority, from any state
            state_d = ST_STALL;
        end else if (setup_valid) begin
            // setup_nodata / setup_in / setup_out; also stall_exit and restart
            cnt_op = CNT_LOAD;
            if (setup_len == '0) begin
                state_d = ST_SETUP;
                act     = ACT_STATUS;
            end else if (setup_in) begin
                state_d = ST_TX;
                act     = ACT_ARM_TX;
            end else begin
                state_d = ST_RX;
                act     = ACT_ARM_RX;
            end
        end else begin
            unique case (state_q)
                ST_SETUP: begin
                    state_d = ST_SETUP;
                end
                ST_TX: begin
                    if (in_sent) begin
                        if (last_in) begin
                            state_d = ST_TX_END;      // tx_last
                        end else begin
                            act    = ACT_ARM_TX;      // tx_more
                            cnt_op = CNT_SUB_MPS;
                        end
                    end
                end
                ST_RX: begin
                    if (out_rcvd) begin
                        if (rx_end) begin
                            state_d = ST_SETUP;       // rx_end
                            act     = ACT_STATUS;
                        end else begin
                            act    = ACT_ARM_RX;      // rx_more
                            cnt_op = CNT_SUB_OUT;
                        end
                    end
                end
                ST_TX_END: begin
                    if (in_done) begin
                        state_d = ST_SETUP;           // tx_done
                        act     = ACT_STATUS;
                    end
                end
                ST_STALL: begin
                    state_d = ST_STALL;
                end
                default: begin
                    state_d = ST_SETUP;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETUP;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/ep0_strobe_reg.sv
module ep0_strobe_reg
    import ep0_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ep0_act_e    act,
    input  ep0_state_e  state_d,
    output logic        arm_tx,
    output logic        arm_rx,
    output logic        send_status,
    output logic        ep_stall
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_tx      <= 1'b0;
            arm_rx      <= 1'b0;
            send_status <= 1'b0;
            ep_stall    <= 1'b0;
        end else begin
            arm_tx      <= (act == ACT_ARM_TX);
            arm_rx      <= (act == ACT_ARM_RX);
            send_status <= (act == ACT_STATUS);
            ep_stall    <= (state_d == ST_STALL);
        end
    end

endmodule

// File: rtl/ep0_stage_seq.sv
module ep0_stage_seq
    import ep0_seq_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int MPS   = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      setup_valid,
    input  logic                      setup_in,
    input  logic [LEN_W-1:0]          setup_len,
    input  logic                      in_sent,
    input  logic                      out_rcvd,
    input  logic [$clog2(MPS+1)-1:0]  out_len,
    input  logic                      in_done,
    input  logic                      stall_req,
    output logic [2:0]                state,
    output logic                      arm_tx,
    output logic                      arm_rx,
    output logic                      send_status,
    output logic                      ep_stall
);
    localparam int OUT_W = $clog2(MPS+1);

    ep0_state_e  st_q;
    ep0_state_e  st_d;
    ep0_act_e    act;
    ep0_cnt_op_e cnt_op;
    logic        last_in;
    logic        rx_end;

    ep0_remain_ctr #(
        .LEN_W (LEN_W),
        .MPS   (MPS),
        .OUT_W (OUT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (cnt_op),
        .load_len (setup_len),
        .out_len  (out_len),
        .last_in  (last_in),
        .rx_end   (rx_end)
    );

    ep0_stage_fsm #(
        .LEN_W (LEN_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_valid (setup_valid),
        .setup_in    (setup_in),
        .setup_len   (setup_len),
        .in_sent     (in_sent),
        .out_rcvd    (out_rcvd),
        .in_done     (in_done),
        .stall_req   (stall_req),
        .last_in     (last_in),
        .rx_end      (rx_end),
        .state_q     (st_q),
        .state_d     (st_d),
        .act         (act),
        .cnt_op      (cnt_op)
    );

    ep0_strobe_reg u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .state_d     (st_d),
        .arm_tx      (arm_tx),
        .arm_rx      (arm_rx),
        .send_status (send_status),
        .ep_stall    (ep_stall)
    );

    assign state = st_q;

endmodule

// File: rtl/ep0_seq_chk.sv
module ep0_seq_chk #(
    parameter int LEN_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              setup_valid,
    input logic [LEN_W-1:0]  setup_len,
    input logic              in_done,
    input logic              stall_req,
    input logic [2:0]        state,
    input logic              arm_tx,
    input logic              arm_rx,
    input logic              send_status,
    input logic              ep_stall
);
    localparam logic [2:0] S_SETUP  = 3'd1;
    localparam logic [2:0] S_TX_END = 3'd4;
    localparam logic [2:0] S_STALL  = 3'd5;

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arm_tx, arm_rx, send_status}));

    // R9
    stall_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> (state == S_STALL) && ep_stall);

    // R9
    stall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep_stall |-> (state == S_STALL));

    // R10
    stall_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STALL && setup_valid && !stall_req) |=> !ep_stall);

    // R2
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && !stall_req && setup_len == '0)
            |=> (state == S_SETUP) && send_status);

    // R6
    txend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TX_END && !in_done && !setup_valid && !stall_req)
            |=> (state == S_TX_END) && !send_status);

    // R6
    txend_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TX_END && in_done && !setup_valid && !stall_req)
            |=> (state == S_SETUP) && send_status);

endmodule

bind ep0_stage_seq ep0_seq_chk #(.LEN_W(LEN_W)) u_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_valid (setup_valid),
    .setup_len   (setup_len),
    .in_done     (in_done),
    .stall_req   (stall_req),
    .state       (state),
    .arm_tx      (arm_tx),
    .arm_rx      (arm_rx),
    .send_status (send_status),
    .ep_stall    (ep_stall)
);

// File: tb/sim_ep0_stage_seq.sv
module sim_ep0_stage_seq;
    localparam int LEN_W = 16;
    localparam int MPS   = 64;
    localparam int OUT_W = $clog2(MPS+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_valid = 1'b0, setup_in = 1'b0;
    logic [LEN_W-1:0] setup_len = '0;
    logic in_sent = 1'b0, out_rcvd = 1'b0, in_done = 1'b0, stall_req = 1'b0;
    logic [OUT_W-1:0] out_len = '0;
    logic [2:0] state;
    logic arm_tx, arm_rx, send_status, ep_stall;

    int n_chk = 0;
    int n_fail = 0;
    int m_state = 1;
    int m_rem = 0;

    always #10 clk = ~clk;

    ep0_stage_seq #(.LEN_W(LEN_W), .MPS(MPS)) u0 (
        .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_in(setup_in),
        .setup_len(setup_len), .in_sent(in_sent), .out_rcvd(out_rcvd),
        .out_len(out_len), .in_done(in_done), .stall_req(stall_req),
        .state(state), .arm_tx(arm_tx), .arm_rx(arm_rx),
        .send_status(send_status), .ep_stall(ep_stall));

    // Reference model: returns {state[2:0], arm_tx, arm_rx, send_status, ep_stall}
    function automatic logic [6:0] ref_step(logic st, logic su, logic din, int len,
                                            logic isent, logic orcv, int olen, logic idone);
        int ns = m_state;
        logic tx = 0, rx = 0, sts = 0;
        if (st) ns = 5;
        else if (su) begin
            m_rem = len;
            if (len == 0) begin ns = 1; sts = 1; end
            else if (din) begin ns = 2; tx = 1; end
            else begin ns = 3; rx = 1; end
        end else if (m_state == 2 && isent) begin
            if (m_rem <= MPS) ns = 4;
            else begin tx = 1; m_rem = m_rem - MPS; end
        end else if (m_state == 3 && orcv) begin
            if (olen < MPS || m_rem <= olen) begin ns = 1; sts = 1; end
            else begin rx = 1; m_rem = m_rem - olen; end
        end else if (m_state == 4 && idone) begin
            ns = 1; sts = 1;
        end
        m_state = ns;
        return {3'(ns), tx, rx, sts, (ns == 5)};
    endfunction

    task automatic check(string tag, logic [6:0] exp);
        logic [6:0] act = {state, arm_tx, arm_rx, send_status, ep_stall};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got state=%0d tx/rx/st/stall=%b expected state=%0d tx/rx/st/stall=%b",
                     tag, act[6:4], act[3:0], exp[6:4], exp[3:0]);
        end
    endtask

    task automatic step(string tag, logic st, logic su, logic din, int len,
                        logic isent, logic orcv, int olen, logic idone);
        logic [6:0] exp;
        stall_req = st; setup_valid = su; setup_in = din; setup_len = LEN_W'(len);
        in_sent = isent; out_rcvd = orcv; out_len = OUT_W'(olen); in_done = idone;
        exp = ref_step(st, su, din, len, isent, orcv, olen, idone);
        @(posedge clk);
        @(negedge clk);
        check(tag, exp);
        stall_req = 0; setup_valid = 0; in_sent = 0; out_rcvd = 0; in_done = 0;
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        @(negedge clk);
        check("R1 reset", {3'd1, 4'b0000});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {3'd1, 4'b0000});

        // R2 zero-length setup
        step("R2 zero len", 0, 1, 1, 0, 0, 0, 0, 0);
        idle("R2 pulse drop");
        // R12 stray events in SETUP ignored
        step("R12 stray in SETUP", 0, 0, 0, 0, 1, 1, 10, 1);
        // R3 IN of exactly MPS -> one packet then TX_END (R5)
        step("R3 setup in", 0, 1, 1, 64, 0, 0, 0, 0);
        step("R5 last at MPS", 0, 0, 0, 0, 1, 0, 0, 0);
        idle("R6 hold TX_END");
        step("R12 out in TX_END", 0, 0, 0, 0, 0, 1, 5, 0);
        step("R6 done", 0, 0, 0, 0, 0, 0, 0, 1);
        step("R6 in_done ignored", 0, 0, 0, 0, 0, 0, 0, 1);
        // R4 IN of 65
        step("R3 setup in 65", 0, 1, 1, 65, 0, 0, 0, 0);
        step("R4 more", 0, 0, 0, 0, 1, 0, 0, 0);
        step("R5 last", 0, 0, 0, 0, 1, 0, 0, 0);
        step("R6 done 65", 0, 0, 0, 0, 0, 0, 0, 1);
        // R7 short OUT
        step("R3 setup out", 0, 1, 0, 200, 0, 0, 0, 0);
        step("R7 short", 0, 0, 0, 0, 0, 1, 30, 0);
        // R8 OUT of 128: two full packets
        step("R3 setup out 128", 0, 1, 0, 128, 0, 0, 0, 0);
        step("R8 full more", 0, 0, 0, 0, 0, 1, 64, 0);
        step("R8 full end", 0, 0, 0, 0, 0, 1, 64, 0);
        // R9 stall in TX, beats setup
        step("R3 setup in 300", 0, 1, 1, 300, 0, 0, 0, 0);
        step("R9 stall", 1, 1, 1, 5, 0, 0, 0, 0);
        step("R9 stall hold", 0, 0, 0, 0, 1, 1, 64, 1);
        // R10 exit via setup
        step("R10 exit", 0, 1, 0, 10, 0, 0, 0, 0);
        // R11 restart inside RX
        step("R11 restart", 0, 1, 1, 0, 0, 0, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            logic st = ($urandom % 100) < 4;
            logic su = ($urandom % 100) < 12;
            int len = (($urandom % 10) == 0) ? 0 : int'($urandom % 300);
            step("R12 random", st, su, 1'($urandom), len,
                 ($urandom % 3) == 0, ($urandom % 3) == 0,
                 (($urandom % 2) == 0) ? MPS : int'($urandom % (MPS + 1)),
                 ($urandom % 4) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule